// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block turns the system clock into the timing strobes a serial transmitter and receiver need. A single reloadable down-counter divides the system clock by a programmable 12-bit divisor plus one. Its output pulse then serves one of four operating modes. Two of them are asynchronous: the receive strobe runs at the oversampling rate and the transmit strobe fires once per bit, at either standard or double speed. The other two are synchronous. In synchronous master mode the block drives a serial clock of its own onto the external clock pin. In synchronous slave mode it follows a clock that arrives on that pin.

Three control inputs pick the mode. `sync_mode` chooses between asynchronous and synchronous operation. `double_speed` matters only while `sync_mode` is low. `clk_dir_out` matters only while `sync_mode` is high. Every output strobe lasts one system-clock cycle and comes from a register. The strobes are plain control pulses with no handshake, so the transmitter and receiver must take each one in the cycle it appears.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is asserted, `tx_tick`, `rx_tick` and `ext_clk_out` are all 0, whatever the mode inputs are.
- R2: In asynchronous operation `rx_tick` pulses for exactly one cycle every D+1 cycles, where D is the divisor. The first pulse comes D+1 cycles after the clock edge that took the divisor write.
- R3: In standard asynchronous mode (`sync_mode`=0, `double_speed`=0), `tx_tick` fires 16·(D+1) cycles after a divisor write and every 16·(D+1) cycles after that. Each `tx_tick` falls in a cycle that also has `rx_tick`.
- R4: In double-speed asynchronous mode (`sync_mode`=0, `double_speed`=1), `tx_tick` fires every 8·(D+1) cycles, counted from the divisor write.
- R5: In synchronous master mode (`sync_mode`=1, `clk_dir_out`=1), `ext_clk_oe` is 1. `ext_clk_out` is 0 right after a divisor write and then toggles every D+1 cycles. `rx_tick` appears in exactly the cycles in which `ext_clk_out` has just risen, and `tx_tick` appears in exactly the cycles in which it has just fallen.
- R6: In synchronous modes `double_speed` has no effect: master timing with `double_speed`=1 is identical to master timing with `double_speed`=0.
- R7: In synchronous slave mode (`sync_mode`=1, `clk_dir_out`=0), a rising level on `ext_clk_in` that is driven between clock edges yields one `rx_tick`, seen 3 edges later. A falling level yields one `tx_tick` with the same latency. In this mode `ext_clk_oe` and `ext_clk_out` are 0. The external clock must be slower than a quarter of the system clock.
- R8: `ext_pin_active` equals `sync_mode`. In both asynchronous modes `ext_clk_oe` and `ext_clk_out` stay 0, and activity on `ext_clk_in` does not change the strobe timing.
- R9: A divisor write (`baud_div_wr`=1) reloads the counter at once. It also restarts the bit phase and the master clock at 0. A generator pulse that would have fallen on the write cycle is dropped, so the next `rx_tick` comes D_new+1 cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| baud_div | input | 12 | Divisor value D; the generator rate is fclk/(D+1) |
| baud_div_wr | input | 1 | Write strobe that loads `baud_div` into the counter at once |
| sync_mode | input | 1 | 0 = asynchronous, 1 = synchronous |
| double_speed | input | 1 | Selects 8x oversampling instead of 16x; used only in asynchronous mode |
| clk_dir_out | input | 1 | Synchronous clock source: 1 = master (drive the pin), 0 = slave (follow the pin) |
| ext_clk_in | input | 1 | Level on the external clock pin |
| tx_tick | output | 1 | One-cycle transmit bit strobe |
| rx_tick | output | 1 | One-cycle receive sample strobe |
| ext_clk_out | output | 1 | Master serial clock level for the pin |
| ext_clk_oe | output | 1 | Output enable for the external clock pin |
| ext_pin_active | output | 1 | High while the external clock pin is in use (synchronous modes) |

## Verification
The two events that can land in the same cycle are a divisor write and a counter expiry. The bench provokes this by loading D=4 and then issuing a new write of D=2 in exactly the cycle where the counter is at zero. It then checks that no `rx_tick` appears on the edge after the write. It also checks that the strobe train restarts on the new period, with the first pulse 3 cycles later and the bit phase cleared. The same write-versus-pulse ordering is relied on at the start of every sweep run: the cycle of the write is always expected to show no strobes.

// File: rtl/usart_clk_pkg.sv
package usart_clk_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC     = 2'd0,
    MODE_ASYNC_DBL = 2'd1,
    MODE_MASTER    = 2'd2,
    MODE_SLAVE     = 2'd3
  } clk_mode_e;

  // Map the three control inputs onto one of four operating modes.
  // The double-speed input is consulted only on the asynchronous branch.
  function automatic clk_mode_e mode_decode(input logic sync_sel,
                                            input logic dbl_sel,
                                            input logic dir_out);
    if (!sync_sel) return dbl_sel ? MODE_ASYNC_DBL : MODE_ASYNC;
    return dir_out ? MODE_MASTER : MODE_SLAVE;
  endfunction

endpackage

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_value,
  input  logic             div_load,
  output logic             pulse
);

  logic [DIV_W-1:0] cnt;

  // A load in the same cycle as expiry wins: that pulse is dropped.
  assign pulse = (cnt == '0) && !div_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (div_load)        cnt <= div_value;
    else if (cnt == '0)       cnt <= div_value;
    else                      cnt <= cnt - 1'b1;
  end

  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  a_r9_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |=> cnt == $past(div_value));

endmodule

// File: rtl/async_phase.sv
module async_phase #(
  parameter int NORM_OVS = 16,
  parameter int DBL_OVS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dbl,
  input  logic restart,
  input  logic pulse,
  output logic bit_fire
);

  localparam int PH_W = $clog2(NORM_OVS);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] last;

  assign last     = dbl ? PH_W'(DBL_OVS - 1) : PH_W'(NORM_OVS - 1);
  assign bit_fire = en && pulse && (ph >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph <= '0;
    else if (restart || !en) ph <= '0;
    else if (pulse)          ph <= (ph >= last) ? '0 : ph + 1'b1;
  end

endmodule

// File: rtl/master_clk.sv
module master_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  input  logic pulse,
  output logic sclk,
  output logic rise_fire,
  output logic fall_fire
);

  assign rise_fire = en && pulse && !sclk;
  assign fall_fire = en && pulse &&  sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sclk <= 1'b0;
    else if (!en || restart) sclk <= 1'b0;
    else if (pulse)          sclk <= ~sclk;
  end

  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pulse) |=> (!en || sclk != $past(sclk)));

endmodule

// File: rtl/slave_edge.sv
module slave_edge #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise,
  output logic fall
);

  logic [SYNC_DEPTH:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_DEPTH-1:0], ext_in};
  end

  assign rise =  sh[SYNC_DEPTH-1] && !sh[SYNC_DEPTH];
  assign fall = !sh[SYNC_DEPTH-1] &&  sh[SYNC_DEPTH];

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clk_pkg::*;
#(
  parameter int DIV_W      = 12,
  parameter int NORM_OVS   = 16,
  parameter int DBL_OVS    = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             baud_div_wr,
  input  logic             sync_mode,
  input  logic             double_speed,
  input  logic             clk_dir_out,
  input  logic             ext_clk_in,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             ext_clk_out,
  output logic             ext_clk_oe,
  output logic             ext_pin_active
);

  clk_mode_e mode;
  logic gen_pulse, ph_fire, m_rise, m_fall, s_rise, s_fall, sclk;
  logic sel_tx, sel_rx;

  assign mode = mode_decode(sync_mode, double_speed, clk_dir_out);

  baud_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .div_value(baud_div),
    .div_load(baud_div_wr), .pulse(gen_pulse));

  async_phase #(.NORM_OVS(NORM_OVS), .DBL_OVS(DBL_OVS)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(!sync_mode), .dbl(double_speed),
    .restart(baud_div_wr), .pulse(gen_pulse), .bit_fire(ph_fire));

  master_clk u_master (
    .clk(clk), .rst_n(rst_n), .en(mode == MODE_MASTER),
    .restart(baud_div_wr), .pulse(gen_pulse), .sclk(sclk),
    .rise_fire(m_rise), .fall_fire(m_fall));

  slave_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_slave (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_clk_in),
    .rise(s_rise), .fall(s_fall));

  always_comb begin
    sel_tx = 1'b0;
    sel_rx = 1'b0;
    case (mode)
      MODE_ASYNC, MODE_ASYNC_DBL: begin sel_rx = gen_pulse; sel_tx = ph_fire; end
      MODE_MASTER:                begin sel_rx = m_rise;    sel_tx = m_fall;  end
      MODE_SLAVE:                 begin sel_rx = s_rise;    sel_tx = s_fall;  end
      default:                    begin sel_rx = 1'b0;      sel_tx = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      tx_tick <= sel_tx;
      rx_tick <= sel_rx;
    end
  end

  assign ext_clk_out    = sclk;
  assign ext_clk_oe     = (mode == MODE_MASTER);
  assign ext_pin_active = sync_mode;

  a_r3_tx_with_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sync_mode) && tx_tick) |-> rx_tick);

  a_r5_master_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_MASTER) |-> !(tx_tick && rx_tick));

  a_r8_async_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !ext_clk_out);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!tx_tick && !rx_tick && !ext_clk_out));

endmodule

// File: tb/usart_clkgen_test.sv
module usart_clkgen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = '0;
  logic        baud_div_wr = 1'b0;
  logic        sync_mode = 1'b0;
  logic        double_speed = 1'b0;
  logic        clk_dir_out = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        tx_tick, rx_tick, ext_clk_out, ext_clk_oe, ext_pin_active;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usart_clkgen uut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .baud_div_wr(baud_div_wr),
    .sync_mode(sync_mode), .double_speed(double_speed), .clk_dir_out(clk_dir_out),
    .ext_clk_in(ext_clk_in), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .ext_clk_out(ext_clk_out), .ext_clk_oe(ext_clk_oe), .ext_pin_active(ext_pin_active));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge right after the write edge.
  task automatic do_write(input int v, output int t);
    baud_div = 12'(v);
    baud_div_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    baud_div_wr = 1'b0;
    t = cyc;
  endtask

  // kind: 0 standard async, 1 double async, 2 master, 3 master with double_speed=1
  task automatic check_window(input int kind, input int d, input int t0, input int len);
    int p, ovs, bad_rx, bad_tx, bad_clk, bad_pin;
    string rtag, ttag;
    p = d + 1;
    ovs = (kind == 1) ? 8 : 16;
    bad_rx = 0; bad_tx = 0; bad_clk = 0; bad_pin = 0;
    for (int k = 0; k < len; k++) begin
      int erx, etx, eclk, n;
      if (kind < 2) begin
        erx  = (k > 0 && k % p == 0) ? 1 : 0;
        etx  = (k > 0 && k % (p * ovs) == 0) ? 1 : 0;
        eclk = 0;
        if (k % 3 == 0) ext_clk_in = ~ext_clk_in;   // R8: pin noise must not matter
      end else begin
        n    = k / p;
        erx  = (k > 0 && k % p == 0 && n % 2 == 1) ? 1 : 0;
        etx  = (k > 0 && k % p == 0 && n % 2 == 0) ? 1 : 0;
        eclk = n % 2;
      end
      if (int'(rx_tick) != erx) bad_rx++;
      if (int'(tx_tick) != etx) bad_tx++;
      if (int'(ext_clk_out) != eclk) bad_clk++;
      if (int'(ext_clk_oe) != (kind >= 2 ? 1 : 0) ||
          int'(ext_pin_active) != (kind >= 2 ? 1 : 0)) bad_pin++;
      @(negedge clk);
    end
    case (kind)
      0: begin rtag = "R2 rx period std";  ttag = "R3 tx period std"; end
      1: begin rtag = "R2 rx period dbl";  ttag = "R4 tx period dbl"; end
      2: begin rtag = "R5 master rx";      ttag = "R5 master tx";     end
      default: begin rtag = "R6 master rx dbl ignored"; ttag = "R6 master tx dbl ignored"; end
    endcase
    chk($sformatf("%s d=%0d mismatch cycles", rtag, d), bad_rx, 0);
    chk($sformatf("%s d=%0d mismatch cycles", ttag, d), bad_tx, 0);
    chk($sformatf("R5/R8 clock level d=%0d kind=%0d mismatch cycles", d, kind), bad_clk, 0);
    chk($sformatf("R8 pin enable/active d=%0d kind=%0d mismatch cycles", d, kind), bad_pin, 0);
  endtask

  function automatic int slave_lvl(input int c, input int ts);
    if (c < ts) return 0;
    return ((c - ts) / 4) % 2;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, ts, bad_rx, bad_tx, bad_pin;
    int dlist[6] = '{0, 1, 2, 3, 5, 7};
    // R1: reset holds outputs low even with master selected
    sync_mode = 1'b1; clk_dir_out = 1'b1; baud_div = 12'd0;
    repeat (4) @(negedge clk);
    chk("R1 tx_tick in reset", int'(tx_tick), 0);
    chk("R1 rx_tick in reset", int'(rx_tick), 0);
    chk("R1 ext_clk_out in reset", int'(ext_clk_out), 0);
    rst_n = 1'b1;
    sync_mode = 1'b0; clk_dir_out = 1'b0;
    repeat (3) @(negedge clk);

    for (int kind = 0; kind < 4; kind++) begin
      foreach (dlist[i]) begin
        sync_mode    = (kind >= 2);
        clk_dir_out  = (kind >= 2);
        double_speed = (kind == 1 || kind == 3);
        do_write(dlist[i], t0);
        check_window(kind, dlist[i], t0, 3 * 16 * (dlist[i] + 1) + 2);
      end
    end

    // R9: write lands exactly on the expiry cycle
    sync_mode = 1'b0; double_speed = 1'b0; clk_dir_out = 1'b0;
    do_write(4, t0);
    while (cyc != t0 + 4) @(negedge clk);
    do_write(2, t1);
    chk("R9 write edge follows expiry cycle", t1 - t0, 5);
    chk("R9 expiry pulse dropped on write", int'(rx_tick), 0);
    check_window(0, 2, t1, 3 * 16 * 3 + 2);

    // R7: slave mode follows the external pin
    sync_mode = 1'b1; clk_dir_out = 1'b0; double_speed = 1'b1;
    ext_clk_in = 1'b0;
    repeat (6) @(negedge clk);
    ts = cyc;
    bad_rx = 0; bad_tx = 0; bad_pin = 0;
    for (int k = 0; k < 96; k++) begin
      int c, erx, etx;
      c = cyc;
      erx = (slave_lvl(c - 3, ts) == 1 && slave_lvl(c - 4, ts) == 0) ? 1 : 0;
      etx = (slave_lvl(c - 3, ts) == 0 && slave_lvl(c - 4, ts) == 1) ? 1 : 0;
      if (int'(rx_tick) != erx) bad_rx++;
      if (int'(tx_tick) != etx) bad_tx++;
      if (ext_clk_oe || ext_clk_out || !ext_pin_active) bad_pin++;
      ext_clk_in = slave_lvl(c, ts)[0];
      @(negedge clk);
    end
    chk("R7 slave rx on rising edge mismatch cycles", bad_rx, 0);
    chk("R7 slave tx on falling edge mismatch cycles", bad_tx, 0);
    chk("R7 slave pin not driven mismatch cycles", bad_pin, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule